// File: doc/BRIEF.md
# Register Rename Stage with Move and Zero Elimination

This block maps 16 architectural registers onto a pool of 64 physical registers and renames one micro-op per cycle. It reads the physical tags of both sources from the alias table. It reports the mapping that the destination had before, so that commit can release that register later. It gives the destination a physical register taken from the free pool. Each physical register carries a ready bit that writeback sets, and a reference count. A register counts as free only while its count is zero.

Two kinds of micro-op are finished inside rename and never go to execution. A register-to-register move whose source is already ready only redirects the destination entry to the source's physical register and raises that register's count. An XOR or SUB whose two source registers are the same gets a new register that is marked ready and known to hold zero. Four checkpoints capture the alias table and all reference counts. Restoring a checkpoint recovers from a mispredicted branch, and releases that commit made after the snapshot are still honoured.

Top module: `rn_rename`

## Requirements
- R1: After reset, architectural register i maps to physical register i with its ready bit set, and physical registers 16 to 63 are free.
- R2: The micro-op class is encoded as 0 = plain op, 1 = move, 2 = XOR, 3 = SUB, 4 = no destination. A class with a destination that is renamed normally reads its source tags from the table, takes the lowest-numbered free physical register as pdst_o, reports the previous mapping on pdst_old_o, and leaves the new register not ready. A class-4 op allocates nothing and reports pdst_o = 0.
- R3: A move whose source physical register is ready takes no new register. It sets pdst_o to the source tag and raises elim_o, and it increments that register's reference count.
- R4: A move whose source register is not ready is renamed like a plain op, with elim_o low.
- R5: An XOR or SUB with equal source registers gets a new register that is ready at once, with elim_o and zero_o both high. With unequal sources it is renamed normally.
- R6: A writeback of a tag sets that register's ready bit, and later moves from it are eliminated.
- R7: A newly allocated register starts with count 1, and each commit release lowers the count by one. A register returns to the free pool only when its count reaches zero.
- R8: When no register is free, a micro-op that needs one is refused (uop_ready_o low). Eliminated moves and class-4 ops are still accepted.
- R9: A restore brings back the alias table and the reference counts from the chosen checkpoint. Releases that arrive between the save and the restore stay in effect.
- R10: No micro-op is accepted in a cycle that restores a checkpoint.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| uop_valid_i | input | 1 | Micro-op present |
| uop_class_i | input | 3 | Micro-op class (see R2) |
| uop_src1_i | input | 4 | First source architectural register |
| uop_src2_i | input | 4 | Second source architectural register |
| uop_dst_i | input | 4 | Destination architectural register |
| uop_ready_o | output | 1 | Micro-op accepted this cycle if valid |
| psrc1_o | output | 6 | Physical tag of first source |
| psrc2_o | output | 6 | Physical tag of second source |
| psrc1_rdy_o | output | 1 | First source ready |
| psrc2_rdy_o | output | 1 | Second source ready |
| pdst_o | output | 6 | Physical destination tag |
| pdst_old_o | output | 6 | Previous mapping of the destination |
| elim_o | output | 1 | Micro-op completed in rename |
| zero_o | output | 1 | Destination is a ready zero register |
| wb_valid_i | input | 1 | Writeback strobe |
| wb_tag_i | input | 6 | Physical tag written back |
| rel_valid_i | input | 1 | Commit release strobe |
| rel_tag_i | input | 6 | Physical tag released |
| ckpt_save_i | input | 1 | Capture state into a checkpoint |
| ckpt_restore_i | input | 1 | Restore state from a checkpoint |
| ckpt_id_i | input | 2 | Checkpoint slot |

## Verification
The hardest case to reach is a restore that has to bring back the old alias table while keeping a release that commit made after the snapshot. The stimulus saves a slot and then renames a destination, which uses up the next free register. It next releases a register that is older than the snapshot and then restores the slot. The next two allocations must come back as the released register first and then the register the discarded op had taken. Filling the pool also needs a long run of allocations. A loop drains the pool one register at a time before it probes refusal and the cases that are still accepted.

// File: rtl/rn_pkg.sv
package rn_pkg;
  typedef enum logic [2:0] {
    UC_ALU    = 3'd0,
    UC_MOVE   = 3'd1,
    UC_XOR    = 3'd2,
    UC_SUB    = 3'd3,
    UC_NODEST = 3'd4
  } uop_cls_e;
endpackage

// File: rtl/rn_free_pick.sv
module rn_free_pick #(
  parameter int N = 64,
  parameter int W = $clog2(N)
) (
  input  logic [N-1:0] free_i,
  output logic [W-1:0] tag_o,
  output logic         any_o
);
  always_comb begin
    tag_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (free_i[i]) tag_o = W'(i);
    end
  end
  assign any_o = |free_i;
endmodule

// File: rtl/rn_ckpt_bank.sv
module rn_ckpt_bank #(
  parameter int NUM_ARCH = 16,
  parameter int NUM_PHYS = 64,
  parameter int NUM_CKPT = 4,
  parameter int CNT_W    = 6,
  parameter int PW       = $clog2(NUM_PHYS),
  parameter int CKW      = $clog2(NUM_CKPT)
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 save_i,
  input  logic [CKW-1:0]                       id_i,
  input  logic [NUM_ARCH-1:0][PW-1:0]          rat_i,
  input  logic [NUM_PHYS-1:0][CNT_W-1:0]       cnt_i,
  input  logic                                 rel_valid_i,
  input  logic [PW-1:0]                        rel_tag_i,
  output logic [NUM_ARCH-1:0][PW-1:0]          rat_o,
  output logic [NUM_PHYS-1:0][CNT_W-1:0]       cnt_o
);
  logic [NUM_CKPT-1:0][NUM_ARCH-1:0][PW-1:0]    rat_q;
  logic [NUM_CKPT-1:0][NUM_PHYS-1:0][CNT_W-1:0] cnt_q;

  for (genvar c = 0; c < NUM_CKPT; c++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rat_q[c] <= '0;
        cnt_q[c] <= '0;
      end else if (save_i && id_i == CKW'(c)) begin
        rat_q[c] <= rat_i;
        cnt_q[c] <= cnt_i;
      end else if (rel_valid_i && cnt_q[c][rel_tag_i] != '0) begin
        // commits are older than any live snapshot: keep them current
        cnt_q[c][rel_tag_i] <= cnt_q[c][rel_tag_i] - CNT_W'(1);
      end
    end
  end

  assign rat_o = rat_q[id_i];
  assign cnt_o = cnt_q[id_i];
endmodule

// File: rtl/rn_rename.sv
module rn_rename import rn_pkg::*; #(
  parameter int NUM_ARCH = 16,
  parameter int NUM_PHYS = 64,
  parameter int NUM_CKPT = 4,
  parameter int CNT_W    = 6,
  localparam int AW      = $clog2(NUM_ARCH),
  localparam int PW      = $clog2(NUM_PHYS),
  localparam int CKW     = $clog2(NUM_CKPT)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           uop_valid_i,
  input  logic [2:0]     uop_class_i,
  input  logic [AW-1:0]  uop_src1_i,
  input  logic [AW-1:0]  uop_src2_i,
  input  logic [AW-1:0]  uop_dst_i,
  output logic           uop_ready_o,
  output logic [PW-1:0]  psrc1_o,
  output logic [PW-1:0]  psrc2_o,
  output logic           psrc1_rdy_o,
  output logic           psrc2_rdy_o,
  output logic [PW-1:0]  pdst_o,
  output logic [PW-1:0]  pdst_old_o,
  output logic           elim_o,
  output logic           zero_o,
  input  logic           wb_valid_i,
  input  logic [PW-1:0]  wb_tag_i,
  input  logic           rel_valid_i,
  input  logic [PW-1:0]  rel_tag_i,
  input  logic           ckpt_save_i,
  input  logic           ckpt_restore_i,
  input  logic [CKW-1:0] ckpt_id_i
);
  logic [NUM_ARCH-1:0][PW-1:0]    rat_q, rat_live, rat_d, snap_rat;
  logic [NUM_PHYS-1:0][CNT_W-1:0] cnt_q, cnt_live, cnt_d, snap_cnt;
  logic [NUM_PHYS-1:0]            rdy_q, rdy_d, free_vec;
  logic [PW-1:0]                  free_tag, new_tag;
  logic                           free_any;
  uop_cls_e                       cls;
  logic                           has_dst, is_zero, is_elim_mv, need_alloc, fire;

  assign cls        = uop_cls_e'(uop_class_i);
  assign psrc1_o    = rat_q[uop_src1_i];
  assign psrc2_o    = rat_q[uop_src2_i];
  assign psrc1_rdy_o = rdy_q[psrc1_o];
  assign psrc2_rdy_o = rdy_q[psrc2_o];

  assign has_dst    = (cls != UC_NODEST);
  assign is_zero    = (cls == UC_XOR || cls == UC_SUB) && (uop_src1_i == uop_src2_i);
  assign is_elim_mv = (cls == UC_MOVE) && rdy_q[psrc1_o];
  assign need_alloc = has_dst && !is_elim_mv;

  assign uop_ready_o = !ckpt_restore_i && (!need_alloc || free_any);
  assign fire        = uop_valid_i && uop_ready_o;

  assign new_tag    = is_elim_mv ? psrc1_o : free_tag;
  assign pdst_o     = has_dst ? new_tag : '0;
  assign pdst_old_o = has_dst ? rat_q[uop_dst_i] : '0;
  assign elim_o     = is_elim_mv || is_zero;
  assign zero_o     = is_zero;

  for (genvar i = 0; i < NUM_PHYS; i++) begin : g_phys
    logic inc, dec;
    assign free_vec[i]  = (cnt_q[i] == '0);
    assign inc          = fire && has_dst && (new_tag == PW'(i));
    assign dec          = rel_valid_i && (rel_tag_i == PW'(i));
    assign cnt_live[i]  = cnt_q[i] + CNT_W'(inc) - CNT_W'(dec);
    assign cnt_d[i]     = !ckpt_restore_i ? cnt_live[i] :
                          (dec && snap_cnt[i] != '0) ? snap_cnt[i] - CNT_W'(1) : snap_cnt[i];
  end

  always_comb begin
    rat_live = rat_q;
    if (fire && has_dst) rat_live[uop_dst_i] = new_tag;
    rat_d = ckpt_restore_i ? snap_rat : rat_live;
  end

  always_comb begin
    rdy_d = rdy_q;
    if (wb_valid_i) rdy_d[wb_tag_i] = 1'b1;
    if (fire && need_alloc) rdy_d[free_tag] = is_zero;
  end

  rn_free_pick #(.N(NUM_PHYS), .W(PW)) u_pick (
    .free_i (free_vec),
    .tag_o  (free_tag),
    .any_o  (free_any)
  );

  rn_ckpt_bank #(
    .NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS), .NUM_CKPT(NUM_CKPT),
    .CNT_W(CNT_W), .PW(PW), .CKW(CKW)
  ) u_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .save_i      (ckpt_save_i && !ckpt_restore_i),
    .id_i        (ckpt_id_i),
    .rat_i       (rat_live),
    .cnt_i       (cnt_live),
    .rel_valid_i (rel_valid_i),
    .rel_tag_i   (rel_tag_i),
    .rat_o       (snap_rat),
    .cnt_o       (snap_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int a = 0; a < NUM_ARCH; a++) rat_q[a] <= PW'(a);
      for (int p = 0; p < NUM_PHYS; p++) begin
        cnt_q[p] <= (p < NUM_ARCH) ? CNT_W'(1) : '0;
        rdy_q[p] <= (p < NUM_ARCH);
      end
    end else begin
      rat_q <= rat_d;
      cnt_q <= cnt_d;
      rdy_q <= rdy_d;
    end
  end
endmodule

// File: rtl/rn_rename_chk.sv
module rn_rename_chk #(
  parameter int NUM_ARCH = 16,
  parameter int NUM_PHYS = 64,
  parameter int CNT_W    = 6,
  parameter int PW       = $clog2(NUM_PHYS)
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           fire_i,
  input logic                           need_alloc_i,
  input logic [PW-1:0]                  pdst_i,
  input logic                           elim_i,
  input logic                           zero_i,
  input logic                           rel_valid_i,
  input logic [PW-1:0]                  rel_tag_i,
  input logic [NUM_ARCH-1:0][PW-1:0]    rat_i,
  input logic [NUM_PHYS-1:0][CNT_W-1:0] cnt_i,
  input logic [NUM_PHYS-1:0]            rdy_i
);
  logic             prev_alloc, prev_zero, prev_mv, prev_rel_hit, mapped;
  logic [PW-1:0]    prev_tag;
  logic [CNT_W-1:0] prev_cnt;

  always_comb begin
    mapped = 1'b0;
    for (int a = 0; a < NUM_ARCH; a++) mapped |= (rat_i[a] == pdst_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_alloc <= 1'b0; prev_zero <= 1'b0; prev_mv <= 1'b0; prev_rel_hit <= 1'b0;
      prev_tag <= '0; prev_cnt <= '0;
    end else begin
      prev_alloc   <= fire_i && need_alloc_i;
      prev_zero    <= fire_i && zero_i;
      prev_mv      <= fire_i && elim_i && !zero_i;
      prev_rel_hit <= rel_valid_i && rel_tag_i == pdst_i;
      prev_tag     <= pdst_i;
      prev_cnt     <= cnt_i[pdst_i];
    end
  end

  AST_ALLOC_UNMAPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i && need_alloc_i |-> !mapped); // R2
  AST_ALLOC_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prev_alloc && !prev_zero |-> !rdy_i[prev_tag]); // R2
  AST_ELIM_COUNT_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prev_mv && !prev_rel_hit |-> cnt_i[prev_tag] == prev_cnt + CNT_W'(1)); // R3
  AST_ZERO_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prev_zero |-> rdy_i[prev_tag]); // R5
  AST_ALLOC_COUNT_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prev_alloc |-> cnt_i[prev_tag] == CNT_W'(1)); // R7
  AST_REL_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_valid_i |-> cnt_i[rel_tag_i] != '0); // R7
endmodule

bind rn_rename rn_rename_chk #(
  .NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS), .CNT_W(CNT_W), .PW(PW)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .fire_i       (fire),
  .need_alloc_i (need_alloc),
  .pdst_i       (pdst_o),
  .elim_i       (elim_o),
  .zero_i       (zero_o),
  .rel_valid_i  (rel_valid_i),
  .rel_tag_i    (rel_tag_i),
  .rat_i        (rat_q),
  .cnt_i        (cnt_q),
  .rdy_i        (rdy_q)
);

// File: tb/rn_rename_tb.sv
module rn_rename_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       uop_valid_i, uop_ready_o, psrc1_rdy_o, psrc2_rdy_o, elim_o, zero_o;
  logic [2:0] uop_class_i;
  logic [3:0] uop_src1_i, uop_src2_i, uop_dst_i;
  logic [5:0] psrc1_o, psrc2_o, pdst_o, pdst_old_o, wb_tag_i, rel_tag_i;
  logic       wb_valid_i, rel_valid_i, ckpt_save_i, ckpt_restore_i;
  logic [1:0] ckpt_id_i;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  rn_rename u_dut (.*);

  // {class, s1, s2, d, psrc1, psrc2, pdst, pdst_old, elim, zero}
  localparam int NV = 10;
  localparam logic [40:0] VECS [NV] = '{
    {3'd0, 4'd2,  4'd3,  4'd1,  6'd2,  6'd3,  6'd16, 6'd1,  1'b0, 1'b0},
    {3'd1, 4'd5,  4'd0,  4'd4,  6'd5,  6'd0,  6'd5,  6'd4,  1'b1, 1'b0},
    {3'd0, 4'd4,  4'd1,  4'd6,  6'd5,  6'd16, 6'd17, 6'd6,  1'b0, 1'b0},
    {3'd1, 4'd1,  4'd0,  4'd7,  6'd16, 6'd0,  6'd18, 6'd7,  1'b0, 1'b0},
    {3'd2, 4'd9,  4'd9,  4'd8,  6'd9,  6'd9,  6'd19, 6'd8,  1'b1, 1'b1},
    {3'd2, 4'd9,  4'd11, 4'd10, 6'd9,  6'd11, 6'd20, 6'd10, 1'b0, 1'b0},
    {3'd3, 4'd12, 4'd12, 4'd12, 6'd12, 6'd12, 6'd21, 6'd12, 1'b1, 1'b1},
    {3'd1, 4'd8,  4'd0,  4'd13, 6'd19, 6'd0,  6'd19, 6'd13, 1'b1, 1'b0},
    {3'd4, 4'd13, 4'd7,  4'd0,  6'd19, 6'd18, 6'd0,  6'd0,  1'b0, 1'b0},
    {3'd0, 4'd13, 4'd13, 4'd0,  6'd19, 6'd19, 6'd22, 6'd0,  1'b0, 1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    uop_valid_i = 0; uop_class_i = 0; uop_src1_i = 0; uop_src2_i = 0; uop_dst_i = 0;
    wb_valid_i = 0; wb_tag_i = 0; rel_valid_i = 0; rel_tag_i = 0;
    ckpt_save_i = 0; ckpt_restore_i = 0; ckpt_id_i = 0;
  endtask

  task automatic tick();
    @(posedge clk_i); #1; idle();
  endtask

  task automatic set_uop(input logic v, input logic [2:0] c, input logic [3:0] s1, s2, d);
    uop_valid_i = v; uop_class_i = c; uop_src1_i = s1; uop_src2_i = s2; uop_dst_i = d;
    #1;
  endtask

  task automatic release_tag(input logic [5:0] t);
    rel_valid_i = 1; rel_tag_i = t; tick();
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    idle();
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;
    // R1 reset mapping
    set_uop(0, 3'd0, 4'd0, 4'd15, 4'd3);
    chk("R1 psrc1", psrc1_o, 0);
    chk("R1 psrc2", psrc2_o, 15);
    chk("R1 ready", {psrc1_rdy_o, psrc2_rdy_o}, 3);
    chk("R1 first free", pdst_o, 16);
    idle();

    for (int k = 0; k < NV; k++) begin
      logic [40:0] v;
      v = VECS[k];
      set_uop(1, v[40:38], v[37:34], v[33:30], v[29:26]);
      chk($sformatf("R2 vec%0d ready", k), uop_ready_o, 1);
      chk($sformatf("R2 vec%0d psrc1", k), psrc1_o, v[25:20]);
      chk($sformatf("R2 vec%0d psrc2", k), psrc2_o, v[19:14]);
      chk($sformatf("R3 R4 R5 vec%0d pdst", k), pdst_o, v[13:8]);
      chk($sformatf("R2 vec%0d old", k), pdst_old_o, v[7:2]);
      chk($sformatf("R5 vec%0d elim", k), elim_o, v[1]);
      chk($sformatf("R5 vec%0d zero", k), zero_o, v[0]);
      tick();
    end

    // R2 new dest not ready; R6 writeback sets ready
    set_uop(0, 3'd0, 4'd1, 4'd8, 4'd0);
    chk("R2 new not ready", psrc1_rdy_o, 0);
    chk("R5 zero reg ready", psrc2_rdy_o, 1);
    idle();
    wb_valid_i = 1; wb_tag_i = 6'd16; tick();
    set_uop(0, 3'd0, 4'd1, 4'd1, 4'd0);
    chk("R6 ready after wb", psrc1_rdy_o, 1);
    set_uop(1, 3'd1, 4'd1, 4'd0, 4'd14);
    chk("R6 move now eliminated", elim_o, 1);
    chk("R6 move pdst", pdst_o, 16);
    tick();

    // R7 reference counting
    release_tag(6'd1);
    set_uop(1, 3'd0, 4'd0, 4'd0, 4'd2);
    chk("R7 released reg reused", pdst_o, 1);
    tick();
    set_uop(1, 3'd0, 4'd0, 4'd0, 4'd4);
    chk("R7 alloc", pdst_o, 23);
    chk("R7 old shared", pdst_old_o, 5);
    tick();
    release_tag(6'd5);
    set_uop(1, 3'd0, 4'd0, 4'd0, 4'd3);
    chk("R7 shared reg still held", pdst_o, 24);
    tick();
    set_uop(1, 3'd0, 4'd0, 4'd0, 4'd5);
    chk("R7 alloc", pdst_o, 25);
    tick();
    release_tag(6'd5);
    set_uop(1, 3'd0, 4'd0, 4'd0, 4'd11);
    chk("R7 freed at zero count", pdst_o, 5);
    tick();

    // R9 / R10 checkpoint
    ckpt_save_i = 1; ckpt_id_i = 2'd1; tick();
    set_uop(1, 3'd0, 4'd0, 4'd0, 4'd2);
    chk("R9 spec alloc", pdst_o, 26);
    tick();
    release_tag(6'd2);
    ckpt_restore_i = 1; ckpt_id_i = 2'd1;
    set_uop(1, 3'd0, 4'd2, 4'd0, 4'd9);
    chk("R10 stall on restore", uop_ready_o, 0);
    tick();
    set_uop(0, 3'd0, 4'd2, 4'd0, 4'd9);
    chk("R9 mapping restored", psrc1_o, 1);
    set_uop(1, 3'd0, 4'd0, 4'd0, 4'd9);
    chk("R9 release kept", pdst_o, 2);
    tick();
    set_uop(1, 3'd0, 4'd0, 4'd0, 4'd10);
    chk("R9 count restored", pdst_o, 26);
    chk("R9 old mapping", pdst_old_o, 20);
    tick();

    // R8 drain pool
    for (int k = 0; k < 37; k++) begin
      set_uop(1, 3'd0, 4'd0, 4'd0, 4'd15);
      chk("R8 drain", pdst_o, 27 + k);
      tick();
    end
    set_uop(1, 3'd0, 4'd0, 4'd0, 4'd15);
    chk("R8 refused when empty", uop_ready_o, 0);
    set_uop(1, 3'd1, 4'd13, 4'd0, 4'd0);
    chk("R8 elim move accepted", uop_ready_o, 1);
    chk("R8 elim move pdst", pdst_o, 19);
    tick();
    set_uop(1, 3'd4, 4'd1, 4'd2, 4'd0);
    chk("R8 no-dest accepted", uop_ready_o, 1);
    tick();
    release_tag(6'd3);
    set_uop(1, 3'd0, 4'd0, 4'd0, 4'd15);
    chk("R8 accepted after release", uop_ready_o, 1);
    chk("R8 pdst after release", pdst_o, 3);
    tick();

    done = 1;
    finish_run();
  end
endmodule